// File: doc/BRIEF.md
# Copper Link Bring-Up and Power-Save Controller

This block is the control state machine that decides when a copper Ethernet PHY starts or restarts auto-negotiation. It sets the pace of link pulses while the link is down and steps a failed gigabit attempt down to 100M. It reports the speed and duplex that the link settled on. The analog line interface, the bit-level coding of pulse bursts and the page exchange itself sit outside it. The block only raises a one-cycle `an_start` for the negotiation engine and a one-cycle `lp_send` for the pulse generator. It also locks the advertised-ability word once pulses for the current negotiation have gone out.

Negotiation starts on any of these events:
- a hardware reset or a software reset;
- a write of 1 to the restart bit;
- the power-down bit falling;
- the link dropping;
- auto-negotiation being switched back on.

The states are:
- RESET: entered on either reset.
- START: the one-cycle `an_start` state.
- SEEK: link down, pulses paced by the interval timer.
- LINKED: speed and duplex held.
- PWRDN: quiet.
- FORCED: negotiation disabled, speed and duplex taken from the control bits.

The transitions are:
- RESET or PWRDN goes to START, or to FORCED when negotiation is off.
- START goes to SEEK.
- SEEK goes to LINKED on link-up.
- SEEK goes back to START on a restart or on a gigabit failure that is taken as a downshift.
- LINKED goes to START on a restart or on a link drop.
- SEEK, START and LINKED go to FORCED when negotiation is switched off.
- FORCED goes to START when negotiation is switched back on.
- A software reset (to RESET) and power-down (to PWRDN) override every state.

Top module: `link_bringup_ctrl`

## Requirements
- R1: During hardware reset `an_start`, `lp_send`, `adv_lock`, `res_spd`, `res_full`, `restart_rd` and `swrst_rd` are 0, `tgt_gig` is 1 and `adv_val` holds ADV_DEF. `an_start` is high for one cycle, starting at the first rising edge after `rst_n` is released. When `swrst_wr` is sampled high at an edge, `swrst_rd` reads 1 and `adv_val` returns to ADV_DEF for the next cycle. `an_start` rises one edge later.
- R2: A `restart_wr` sampled at an edge while in SEEK or LINKED raises `an_start` in the next cycle. `restart_rd` reads 1 for exactly that one cycle and then clears itself.
- R3: While `pwr_down` is high, neither `an_start` nor `lp_send` is raised, and `restart_wr` has no effect. When `pwr_down` is first sampled low, `an_start` rises in the next cycle.
- R4: When `link_up` is sampled low in LINKED, `an_start` rises in the next cycle.
- R5: In SEEK, `lp_send` is high only in a cycle with `ms_tick` high. The first tick after a negotiation start sends a pulse. Each later pulse comes PS_MS ticks after the previous one if power saving was on when the previous pulse went out, and NORM_MS ticks after it otherwise.
- R6: Power saving (`cfg_psave`) and downshift (`cfg_dshift`) are both enabled after either reset. With the defaults this gives a PS_MS interval.
- R7: A `gig_fail` sampled in SEEK, with downshift enabled and `tgt_gig` high, restarts negotiation (`an_start` in the next cycle) with `tgt_gig` low. A later `gig_fail` in that attempt has no effect. A negotiating partner that reports speed code 10 then resolves to 100M (code 01).
- R8: With downshift disabled, `gig_fail` causes no restart and `tgt_gig` stays 1. Pulses continue.
- R9: The downshift is cleared (`tgt_gig` back to 1) by either reset or by a link drop from a 100M link.
- R10: `adv_wr` loads `adv_val` until the first pulse of a negotiation. After that `adv_lock` is 1 and writes leave `adv_val` unchanged. `adv_lock` clears in the `an_start` cycle of the next negotiation.
- R11: With a negotiating partner (`prt_an`=1), LINKED shows the partner's speed and duplex from the cycle after `link_up` is sampled. Speed codes are 00 for 10M, 01 for 100M and 10 or 11 for 1000M, the last shown as 10. Outside LINKED and FORCED, `res_spd` and `res_full` are 0.
- R12: With a non-negotiating partner (`prt_an`=0), the link resolves to half duplex. Speed is 10M if `prt_spd` is 00 and 100M otherwise.
- R13: With `aneg_en` low (FORCED), `res_spd` follows `frc_spd` (11 shown as 10) and `res_full` follows `frc_full`. No `an_start` or `lp_send` is raised and `restart_wr` is ignored. Raising `aneg_en` gives `an_start` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware / power-up reset, active low, asynchronous |
| swrst_wr | input | 1 | Write of 1 to the software reset bit |
| restart_wr | input | 1 | Write of 1 to the negotiation restart bit |
| pwr_down | input | 1 | Power-down control bit |
| aneg_en | input | 1 | Auto-negotiation enable bit |
| cfg_wr | input | 1 | Write strobe for the power-save and downshift bits |
| cfg_psave | input | 1 | Power-save enable value to write |
| cfg_dshift | input | 1 | Downshift enable value to write |
| frc_spd | input | 2 | Forced speed code (00 10M, 01 100M, 1x 1000M) |
| frc_full | input | 1 | Forced full duplex |
| adv_wr | input | 1 | Advertised-ability write strobe |
| adv_wdata | input | ADV_W | Advertised-ability write data |
| link_up | input | 1 | Link established indication |
| gig_fail | input | 1 | Gigabit training failed pulse |
| ms_tick | input | 1 | One-cycle millisecond tick |
| prt_an | input | 1 | Partner negotiated (0: parallel detection) |
| prt_spd | input | 2 | Partner speed code |
| prt_full | input | 1 | Partner full duplex |
| an_start | output | 1 | Negotiation start pulse |
| lp_send | output | 1 | Link pulse (burst) send strobe |
| adv_lock | output | 1 | Advertised ability locked |
| adv_val | output | ADV_W | Effective advertised ability |
| tgt_gig | output | 1 | Gigabit targeted in this attempt |
| res_spd | output | 2 | Resolved speed code |
| res_full | output | 1 | Resolved full duplex |
| restart_rd | output | 1 | Self-clearing restart bit readback |
| swrst_rd | output | 1 | Self-clearing software reset bit readback |

## Verification
Each result has a fixed due cycle:
- `an_start` is due in the cycle after the edge that samples its cause. A software reset adds one more edge.
- `lp_send` is combinational and is due in the very cycle its tick is driven.
- The resolved speed and the lock are due one edge after the input that sets them.

The bench drives inputs on the falling edge and samples one nanosecond later. Every expected start and pulse is queued together with its absolute cycle number. A monitor pops one entry per observed strobe and reports both a wrong cycle and any strobe that has no queued entry.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_START  = 3'd1,
        ST_SEEK   = 3'd2,
        ST_LINKED = 3'd3,
        ST_PWRDN  = 3'd4,
        ST_FORCED = 3'd5
    } lbc_state_e;

    localparam logic [1:0] SPD_10   = 2'b00;
    localparam logic [1:0] SPD_100  = 2'b01;
    localparam logic [1:0] SPD_1000 = 2'b10;

endpackage

// File: rtl/lbc_cfg_regs.sv
module lbc_cfg_regs #(
    parameter int ADV_W = 10,
    parameter logic [ADV_W-1:0] ADV_DEF = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swrst_wr,
    input  logic             restart_wr,
    input  logic             cfg_wr,
    input  logic             cfg_psave,
    input  logic             cfg_dshift,
    input  logic             adv_wr,
    input  logic [ADV_W-1:0] adv_wdata,
    input  logic             adv_lock,
    output logic             swrst_rd,
    output logic             restart_rd,
    output logic             psave_q,
    output logic             dshift_en_q,
    output logic [ADV_W-1:0] adv_q
);

    // self-clearing bits: read back as 1 for the cycle after the write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swrst_rd   <= 1'b0;
            restart_rd <= 1'b0;
        end else begin
            swrst_rd   <= swrst_wr;
            restart_rd <= restart_wr;
        end
    end

    // persistent configuration, reset by either reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psave_q     <= 1'b1;
            dshift_en_q <= 1'b1;
            adv_q       <= ADV_DEF;
        end else if (swrst_wr) begin
            psave_q     <= 1'b1;
            dshift_en_q <= 1'b1;
            adv_q       <= ADV_DEF;
        end else begin
            if (cfg_wr) begin
                psave_q     <= cfg_psave;
                dshift_en_q <= cfg_dshift;
            end
            if (adv_wr && !adv_lock) begin
                adv_q <= adv_wdata;
            end
        end
    end

endmodule

// File: rtl/lbc_pulse_timer.sv
module lbc_pulse_timer #(
    parameter int PS_MS   = 50,
    parameter int NORM_MS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic tick,
    input  logic psave,
    output logic fire
);

    localparam int MAXV = (PS_MS > NORM_MS) ? PS_MS : NORM_MS;
    localparam int CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] PS_V   = CW'(PS_MS);
    localparam logic [CW-1:0] NORM_V = CW'(NORM_MS);
    localparam logic [CW-1:0] ONE_V  = CW'(1);

    logic [CW-1:0] cnt_q;

    assign fire = run && tick && (cnt_q == ONE_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ONE_V;
        end else if (load) begin
            cnt_q <= ONE_V;
        end else if (run && tick) begin
            if (cnt_q == ONE_V) begin
                cnt_q <= psave ? PS_V : NORM_V;
            end else begin
                cnt_q <= cnt_q - ONE_V;
            end
        end
    end

endmodule

// File: rtl/lbc_fsm.sv
module lbc_fsm
    import lbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       swrst_wr,
    input  logic       restart_wr,
    input  logic       pwr_down,
    input  logic       aneg_en,
    input  logic       link_up,
    input  logic       gig_fail,
    input  logic       dshift_en,
    input  logic       lp_fire,
    input  logic [1:0] held_spd,
    output lbc_state_e st_q,
    output logic       an_start,
    output logic       tmr_load,
    output logic       tmr_run,
    output logic       capture,
    output logic       dshift_q,
    output logic       lock_q
);

    lbc_state_e nxt;
    logic       ds_take;

    // next-state selection
    always_comb begin
        nxt     = st_q;
        ds_take = 1'b0;
        if (swrst_wr) begin
            nxt = ST_RESET;
        end else if (pwr_down) begin
            nxt = ST_PWRDN;
        end else begin
            unique case (st_q)
                ST_RESET, ST_PWRDN: nxt = aneg_en ? ST_START : ST_FORCED;
                ST_START:           nxt = aneg_en ? ST_SEEK : ST_FORCED;
                ST_SEEK: begin
                    if (!aneg_en) begin
                        nxt = ST_FORCED;
                    end else if (restart_wr) begin
                        nxt = ST_START;
                    end else if (link_up) begin
                        nxt = ST_LINKED;
                    end else if (gig_fail && dshift_en && !dshift_q) begin
                        nxt     = ST_START;
                        ds_take = 1'b1;
                    end
                end
                ST_LINKED: begin
                    if (!aneg_en) begin
                        nxt = ST_FORCED;
                    end else if (restart_wr || !link_up) begin
                        nxt = ST_START;
                    end
                end
                ST_FORCED: begin
                    if (aneg_en) begin
                        nxt = ST_START;
                    end
                end
                default: nxt = ST_RESET;
            endcase
        end
    end

    // state register and per-attempt flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_RESET;
            dshift_q <= 1'b0;
            lock_q   <= 1'b0;
        end else begin
            st_q   <= nxt;
            lock_q <= ((nxt == ST_SEEK) || (nxt == ST_LINKED)) && (lock_q || lp_fire);
            if (swrst_wr) begin
                dshift_q <= 1'b0;
            end else if (ds_take) begin
                dshift_q <= 1'b1;
            end else if ((st_q == ST_LINKED) && !link_up && (held_spd == SPD_100)) begin
                dshift_q <= 1'b0;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        an_start = (st_q == ST_START);
        tmr_load = (st_q == ST_START);
        tmr_run  = (st_q == ST_SEEK);
        capture  = (st_q == ST_SEEK) && (nxt == ST_LINKED);
    end

endmodule

// File: rtl/lbc_resolve.sv
module lbc_resolve
    import lbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lbc_state_e st_q,
    input  logic       capture,
    input  logic       dshift_q,
    input  logic       prt_an,
    input  logic [1:0] prt_spd,
    input  logic       prt_full,
    input  logic [1:0] frc_spd,
    input  logic       frc_full,
    output logic [1:0] held_spd,
    output logic [1:0] res_spd,
    output logic       res_full
);

    logic held_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_spd  <= SPD_10;
            held_full <= 1'b0;
        end else if (capture) begin
            if (prt_an) begin
                if (prt_spd[1]) begin
                    held_spd <= dshift_q ? SPD_100 : SPD_1000;
                end else begin
                    held_spd <= prt_spd;
                end
                held_full <= prt_full;
            end else begin
                // parallel detection: half duplex, 10M or 100M only
                held_spd  <= (prt_spd == SPD_10) ? SPD_10 : SPD_100;
                held_full <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_LINKED: begin
                res_spd  = held_spd;
                res_full = held_full;
            end
            ST_FORCED: begin
                res_spd  = frc_spd[1] ? SPD_1000 : {1'b0, frc_spd[0]};
                res_full = frc_full;
            end
            default: begin
                res_spd  = SPD_10;
                res_full = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl
    import lbc_pkg::*;
#(
    parameter int ADV_W = 10,
    parameter logic [ADV_W-1:0] ADV_DEF = 10'h1E1,
    parameter int PS_MS   = 50,
    parameter int NORM_MS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swrst_wr,
    input  logic             restart_wr,
    input  logic             pwr_down,
    input  logic             aneg_en,
    input  logic             cfg_wr,
    input  logic             cfg_psave,
    input  logic             cfg_dshift,
    input  logic [1:0]       frc_spd,
    input  logic             frc_full,
    input  logic             adv_wr,
    input  logic [ADV_W-1:0] adv_wdata,
    input  logic             link_up,
    input  logic             gig_fail,
    input  logic             ms_tick,
    input  logic             prt_an,
    input  logic [1:0]       prt_spd,
    input  logic             prt_full,
    output logic             an_start,
    output logic             lp_send,
    output logic             adv_lock,
    output logic [ADV_W-1:0] adv_val,
    output logic             tgt_gig,
    output logic [1:0]       res_spd,
    output logic             res_full,
    output logic             restart_rd,
    output logic             swrst_rd
);

    lbc_state_e st_q;
    logic       psave_q;
    logic       dshift_en_q;
    logic       tmr_load;
    logic       tmr_run;
    logic       capture;
    logic       dshift_q;
    logic       lock_q;
    logic       fire;
    logic [1:0] held_spd;

    lbc_cfg_regs #(
        .ADV_W   (ADV_W),
        .ADV_DEF (ADV_DEF)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .swrst_wr    (swrst_wr),
        .restart_wr  (restart_wr),
        .cfg_wr      (cfg_wr),
        .cfg_psave   (cfg_psave),
        .cfg_dshift  (cfg_dshift),
        .adv_wr      (adv_wr),
        .adv_wdata   (adv_wdata),
        .adv_lock    (lock_q),
        .swrst_rd    (swrst_rd),
        .restart_rd  (restart_rd),
        .psave_q     (psave_q),
        .dshift_en_q (dshift_en_q),
        .adv_q       (adv_val)
    );

    lbc_pulse_timer #(
        .PS_MS   (PS_MS),
        .NORM_MS (NORM_MS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (tmr_run),
        .tick  (ms_tick),
        .psave (psave_q),
        .fire  (fire)
    );

    lbc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .swrst_wr   (swrst_wr),
        .restart_wr (restart_wr),
        .pwr_down   (pwr_down),
        .aneg_en    (aneg_en),
        .link_up    (link_up),
        .gig_fail   (gig_fail),
        .dshift_en  (dshift_en_q),
        .lp_fire    (fire),
        .held_spd   (held_spd),
        .st_q       (st_q),
        .an_start   (an_start),
        .tmr_load   (tmr_load),
        .tmr_run    (tmr_run),
        .capture    (capture),
        .dshift_q   (dshift_q),
        .lock_q     (lock_q)
    );

    lbc_resolve u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_q     (st_q),
        .capture  (capture),
        .dshift_q (dshift_q),
        .prt_an   (prt_an),
        .prt_spd  (prt_spd),
        .prt_full (prt_full),
        .frc_spd  (frc_spd),
        .frc_full (frc_full),
        .held_spd (held_spd),
        .res_spd  (res_spd),
        .res_full (res_full)
    );

    assign lp_send  = fire;
    assign adv_lock = lock_q;
    assign tgt_gig  = !dshift_q;

endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
    parameter int ADV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             swrst_wr,
    input logic             restart_wr,
    input logic             pwr_down,
    input logic             ms_tick,
    input logic             an_start,
    input logic             lp_send,
    input logic             adv_lock,
    input logic [ADV_W-1:0] adv_val,
    input logic             restart_rd
);

    assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        an_start |=> !an_start);

    assert_restart_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_rd |-> $past(restart_wr));

    assert_restart_selfclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_rd && !restart_wr) |=> !restart_rd);

    assert_pwrdn_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && $past(pwr_down)) |-> (!an_start && !lp_send));

    assert_pulse_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lp_send |-> ms_tick);

    assert_start_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        an_start |-> !lp_send);

    assert_adv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_lock && !swrst_wr) |=> $stable(adv_val));

endmodule

bind link_bringup_ctrl lbc_checker #(.ADV_W(ADV_W)) u_lbc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .swrst_wr   (swrst_wr),
    .restart_wr (restart_wr),
    .pwr_down   (pwr_down),
    .ms_tick    (ms_tick),
    .an_start   (an_start),
    .lp_send    (lp_send),
    .adv_lock   (adv_lock),
    .adv_val    (adv_val),
    .restart_rd (restart_rd)
);

// File: tb/test_link_bringup_ctrl.sv
`timescale 1ns/1ps
module test_link_bringup_ctrl;

    localparam int ADV_W = 10;
    localparam logic [ADV_W-1:0] ADV_DEF = 10'h1E1;
    localparam int K_START = 0;
    localparam int K_LP    = 1;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic swrst_wr = 0, restart_wr = 0, pwr_down = 0, aneg_en = 1;
    logic cfg_wr = 0, cfg_psave = 0, cfg_dshift = 0;
    logic [1:0] frc_spd = 2'b00;
    logic frc_full = 0, adv_wr = 0;
    logic [ADV_W-1:0] adv_wdata = '0;
    logic link_up = 0, gig_fail = 0, ms_tick = 0;
    logic prt_an = 1;
    logic [1:0] prt_spd = 2'b00;
    logic prt_full = 0;
    logic an_start, lp_send, adv_lock, tgt_gig, res_full, restart_rd, swrst_rd;
    logic [ADV_W-1:0] adv_val;
    logic [1:0] res_spd;

    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    int   tk_left = 1;
    int   ivl = 50;
    bit   done = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    link_bringup_ctrl #(.ADV_W(ADV_W), .ADV_DEF(ADV_DEF)) i_link_bringup_ctrl (
        .clk(clk), .rst_n(rst_n), .swrst_wr(swrst_wr), .restart_wr(restart_wr),
        .pwr_down(pwr_down), .aneg_en(aneg_en), .cfg_wr(cfg_wr),
        .cfg_psave(cfg_psave), .cfg_dshift(cfg_dshift), .frc_spd(frc_spd),
        .frc_full(frc_full), .adv_wr(adv_wr), .adv_wdata(adv_wdata),
        .link_up(link_up), .gig_fail(gig_fail), .ms_tick(ms_tick),
        .prt_an(prt_an), .prt_spd(prt_spd), .prt_full(prt_full),
        .an_start(an_start), .lp_send(lp_send), .adv_lock(adv_lock),
        .adv_val(adv_val), .tgt_gig(tgt_gig), .res_spd(res_spd),
        .res_full(res_full), .restart_rd(restart_rd), .swrst_rd(swrst_rd)
    );

    task automatic push(int kind, int c, string req);
        exp_t e;
        e.kind = kind;
        e.cyc  = c;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // driver helper: one-cycle tick; model=1 queues the pulse the requirements predict
    task automatic tick(bit model);
        ms_tick = 1'b1;
        if (model) begin
            tk_left--;
            if (tk_left == 0) begin
                push(K_LP, cyc, "R5,R6");
                tk_left = ivl;
            end
        end
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic match(int kind);
        exp_t e;
        n_vec++;
        if (q.size() == 0) begin
            n_bad++;
            $display("FAIL R3,R8,R13 unexpected %s: actual cycle %0d expected none",
                     (kind == K_START) ? "an_start" : "lp_send", cyc);
        end else begin
            e = q.pop_front();
            if (e.kind != kind || e.cyc != cyc) begin
                n_bad++;
                $display("FAIL %s strobe: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                         e.req, kind, cyc, e.kind, e.cyc);
            end
        end
    endtask

    // monitor: sample 1 ns after each falling edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (an_start) match(K_START);
            if (lp_send)  match(K_LP);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset an_start", int'(an_start), 0);
        chk("R1", "reset lp_send", int'(lp_send), 0);
        chk("R1", "reset adv_lock", int'(adv_lock), 0);
        chk("R1", "reset res_spd", int'(res_spd), 0);
        chk("R1", "reset tgt_gig", int'(tgt_gig), 1);
        chk("R1", "reset adv_val", int'(adv_val), int'(ADV_DEF));
        chk("R1", "reset restart_rd", int'(restart_rd), 0);

        // hardware reset release -> start
        @(negedge clk);
        rst_n = 1'b1;
        push(K_START, cyc + 1, "R1");
        tk_left = 1; ivl = 50;
        repeat (2) @(negedge clk);

        // advertisement write before first pulse is taken
        adv_wr = 1'b1; adv_wdata = 10'h0A5;
        @(negedge clk);
        adv_wr = 1'b0;
        #1 chk("R10", "adv before lock", int'(adv_val), 'h0A5);
        @(negedge clk);
        tick(1);
        #1 chk("R10", "adv_lock after first pulse", int'(adv_lock), 1);
        @(negedge clk);
        adv_wr = 1'b1; adv_wdata = 10'h03C;
        @(negedge clk);
        adv_wr = 1'b0;
        #1 chk("R10", "adv write ignored", int'(adv_val), 'h0A5);
        @(negedge clk);
        repeat (50) tick(1);          // R6: default 50-tick spacing

        // power save off, restart
        cfg_wr = 1'b1; cfg_psave = 1'b0; cfg_dshift = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        ivl = 16;
        restart_wr = 1'b1;
        push(K_START, cyc + 1, "R2");
        @(negedge clk);
        restart_wr = 1'b0;
        #1;
        chk("R2", "restart_rd set", int'(restart_rd), 1);
        chk("R10", "lock cleared at start", int'(adv_lock), 0);
        @(negedge clk);
        #1 chk("R2", "restart_rd self-clear", int'(restart_rd), 0);
        tk_left = 1;
        @(negedge clk);
        repeat (17) tick(1);          // R5: 16-tick spacing

        // gigabit link with negotiating partner
        prt_an = 1'b1; prt_spd = 2'b10; prt_full = 1'b1; link_up = 1'b1;
        @(negedge clk);
        #1;
        chk("R11", "gig speed", int'(res_spd), 2);
        chk("R11", "gig duplex", int'(res_full), 1);
        @(negedge clk);
        link_up = 1'b0;
        push(K_START, cyc + 1, "R4");
        @(negedge clk);
        #1 chk("R11", "speed idle after drop", int'(res_spd), 0);
        @(negedge clk);
        tk_left = 1;

        // downshift
        gig_fail = 1'b1;
        push(K_START, cyc + 1, "R7");
        @(negedge clk);
        gig_fail = 1'b0;
        #1 chk("R7", "tgt_gig after downshift", int'(tgt_gig), 0);
        @(negedge clk);
        gig_fail = 1'b1;
        @(negedge clk);
        gig_fail = 1'b0;
        #1 chk("R7", "second gig_fail no effect", int'(tgt_gig), 0);
        @(negedge clk);
        link_up = 1'b1;
        @(negedge clk);
        #1 chk("R7", "gig partner resolves 100M", int'(res_spd), 1);
        @(negedge clk);
        link_up = 1'b0;
        push(K_START, cyc + 1, "R9");
        @(negedge clk);
        #1 chk("R9", "downshift cleared by 100M drop", int'(tgt_gig), 1);
        @(negedge clk);
        tk_left = 1;

        // downshift disabled
        cfg_wr = 1'b1; cfg_psave = 1'b0; cfg_dshift = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        gig_fail = 1'b1;
        @(negedge clk);
        gig_fail = 1'b0;
        @(negedge clk);
        #1 chk("R8", "tgt_gig kept", int'(tgt_gig), 1);
        @(negedge clk);
        tick(1);

        // parallel detection
        prt_an = 1'b0; prt_spd = 2'b01; prt_full = 1'b1; link_up = 1'b1;
        @(negedge clk);
        #1;
        chk("R12", "pd 100 speed", int'(res_spd), 1);
        chk("R12", "pd half duplex", int'(res_full), 0);
        @(negedge clk);
        link_up = 1'b0;
        push(K_START, cyc + 1, "R4");
        repeat (2) @(negedge clk);
        prt_spd = 2'b10;
        link_up = 1'b1;
        @(negedge clk);
        #1;
        chk("R12", "pd gig code -> 100M", int'(res_spd), 1);
        chk("R12", "pd gig code half", int'(res_full), 0);
        @(negedge clk);
        link_up = 1'b0;
        push(K_START, cyc + 1, "R4");
        repeat (2) @(negedge clk);
        tk_left = 1;

        // power down
        pwr_down = 1'b1;
        @(negedge clk);
        repeat (3) tick(0);
        restart_wr = 1'b1;
        @(negedge clk);
        restart_wr = 1'b0;
        @(negedge clk);
        pwr_down = 1'b0;
        push(K_START, cyc + 1, "R3");
        repeat (2) @(negedge clk);
        tk_left = 1;

        // forced mode
        aneg_en = 1'b0; frc_spd = 2'b01; frc_full = 1'b1;
        @(negedge clk);
        #1;
        chk("R13", "forced 100", int'(res_spd), 1);
        chk("R13", "forced full", int'(res_full), 1);
        frc_spd = 2'b11; frc_full = 1'b0;
        #1;
        chk("R13", "forced 11 -> 1000", int'(res_spd), 2);
        chk("R13", "forced half", int'(res_full), 0);
        @(negedge clk);
        repeat (3) tick(0);
        restart_wr = 1'b1;
        @(negedge clk);
        restart_wr = 1'b0;
        @(negedge clk);
        aneg_en = 1'b1;
        push(K_START, cyc + 1, "R13");
        repeat (2) @(negedge clk);

        // software reset restores defaults (psave and dshift were off)
        swrst_wr = 1'b1;
        push(K_START, cyc + 2, "R1");
        @(negedge clk);
        swrst_wr = 1'b0;
        #1;
        chk("R1", "swrst_rd set", int'(swrst_rd), 1);
        chk("R1", "adv default after swrst", int'(adv_val), int'(ADV_DEF));
        repeat (2) @(negedge clk);
        tk_left = 1; ivl = 50;
        repeat (51) tick(1);          // R6: 50-tick spacing restored
        gig_fail = 1'b1;
        push(K_START, cyc + 1, "R6");
        @(negedge clk);
        gig_fail = 1'b0;
        #1 chk("R6", "downshift default on", int'(tgt_gig), 0);

        // hardware reset clears downshift
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk("R9", "downshift cleared by reset", int'(tgt_gig), 1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        push(K_START, cyc + 1, "R1");
        repeat (4) @(negedge clk);

        #2;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            n_bad++;
            $display("FAIL %s missing strobe: actual none expected kind %0d cycle %0d",
                     e.req, e.kind, e.cyc);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule